// File: doc/BRIEF.md
# Preamble-Qualified Lock Detector

This block decides whether a biphase-coded digital audio receiver is locked to its incoming stream. A deframer sends it one-cycle strobes for each frame preamble and each block preamble it detects. It also sends a slot tick once per expected frame period. Two level inputs report whether a carrier is present and whether the measured frame rate lies inside the supported window of 25 kHz to 55 kHz.

While hunting, the detector counts frame preambles. It declares lock when a block preamble follows at least three of them. While locked, it counts slot ticks that pass without any preamble, and it drops lock when four such ticks occur in a row. The status logic receives a level that is high whenever the receiver is out of lock, and a one-cycle strobe on every fall of lock. The strobe lets a sticky error bit record each loss.

Top module: `preamble_lock_detector`

## Requirements
- R1: During and right after reset, `locked` and `lossStrobe` are 0 and `outOfLock` is 1.
- R2: While hunting with the gate open (carrier and rate both good), `locked` becomes 1 on the clock edge that samples a block preamble strobe, provided at least three frame preamble strobes were sampled since the hunt count was last cleared.
- R3: A block preamble sampled while hunting with fewer than three counted frame preambles leaves `locked` at 0 and clears the hunt count to zero.
- R4: A frame preamble strobe and a block preamble strobe in the same cycle act as a block preamble only. The frame preamble is not added to the hunt count.
- R5: While locked, any frame or block preamble strobe clears the run of missed slots to zero.
- R6: While locked, the fourth consecutive slot tick without a preamble makes `locked` 0 on that clock edge. The first three such ticks keep it at 1.
- R7: A slot tick that arrives in the same cycle as a preamble strobe counts as a received preamble, not as a miss.
- R8: When `carrierOk` is 0 at a clock edge, `locked` is 0 after that edge and the hunt count is cleared.
- R9: When `rateOk` is 0 at a clock edge, `locked` is 0 after that edge and the hunt count is cleared.
- R10: `outOfLock` is 1 in any cycle where `locked` is 0 or either `carrierOk` or `rateOk` is 0, with no register delay from the gate inputs.
- R11: `lossStrobe` is 1 for exactly the one cycle in which `locked` has just fallen from 1 to 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| framePre | input | 1 | Frame preamble detected (one-cycle strobe) |
| blockPre | input | 1 | Block preamble detected (one-cycle strobe) |
| slotTick | input | 1 | One strobe per expected frame period |
| carrierOk | input | 1 | Input activity present |
| rateOk | input | 1 | Measured frame rate within 25 kHz to 55 kHz |
| locked | output | 1 | Receiver is locked |
| outOfLock | output | 1 | Out-of-lock status level for the error logic |
| lossStrobe | output | 1 | One-cycle pulse on each loss of lock |

## Verification
Two functions can meet in one cycle here. The first is a slot tick meeting a preamble strobe while locked, where miss counting collides with miss clearing. The second is a frame strobe meeting a block strobe while hunting, where counting collides with the acquisition decision. The bench forces each collision after three prior misses, or after a partial hunt count. It then judges the outcome by how many further empty ticks or frames are needed before lock changes. A wrong priority shifts that number by one, and the bench sees the shift.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef struct packed {
    logic acqInc;
    logic acqClr;
    logic missInc;
    logic missClr;
  } lockCtl_t;

  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} lockState_t;

endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int ACQ_FRAMES = 3,
  parameter int MISS_LIMIT = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  lockCtl_t ctl,
  output logic     acqFull,
  output logic     missLast
);
  localparam int ACQ_W  = $clog2(ACQ_FRAMES + 1);
  localparam int MISS_W = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT) : 1;

  logic [ACQ_W-1:0]  acqCount;
  logic [MISS_W-1:0] missCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acqCount <= '0;
    end else if (ctl.acqClr) begin
      acqCount <= '0;
    end else if (ctl.acqInc) begin
      acqCount <= acqCount + ACQ_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCount <= '0;
    end else if (ctl.missClr) begin
      missCount <= '0;
    end else if (ctl.missInc) begin
      missCount <= missCount + MISS_W'(1);
    end
  end

  assign acqFull = (acqCount == ACQ_W'(ACQ_FRAMES));

  generate
    if (MISS_LIMIT > 1) begin : g_missCmp
      assign missLast = (missCount == MISS_W'(MISS_LIMIT - 1));
    end else begin : g_missOne
      logic unusedMiss;
      assign unusedMiss = |missCount;
      assign missLast   = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     framePre,
  input  logic     blockPre,
  input  logic     slotTick,
  input  logic     gateOk,
  input  logic     acqFull,
  input  logic     missLast,
  output lockCtl_t ctl,
  output logic     locked,
  output logic     lossStrobe
);
  lockState_t state, nextState;
  logic       lossQ;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_HUNT: begin
        ctl.missClr = 1'b1;
        if (!gateOk) begin
          ctl.acqClr = 1'b1;
        end else if (blockPre) begin
          ctl.acqClr = 1'b1;
          if (acqFull) nextState = ST_LOCK;
        end else if (framePre && !acqFull) begin
          ctl.acqInc = 1'b1;
        end
      end
      ST_LOCK: begin
        ctl.acqClr = 1'b1;
        if (!gateOk) begin
          ctl.missClr = 1'b1;
          nextState   = ST_HUNT;
        end else if (framePre || blockPre) begin
          ctl.missClr = 1'b1;
        end else if (slotTick) begin
          if (missLast) begin
            ctl.missClr = 1'b1;
            nextState   = ST_HUNT;
          end else begin
            ctl.missInc = 1'b1;
          end
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_HUNT;
      lossQ <= 1'b0;
    end else begin
      state <= nextState;
      lossQ <= (state == ST_LOCK) && (nextState == ST_HUNT);
    end
  end

  assign locked     = (state == ST_LOCK);
  assign lossStrobe = lossQ;

endmodule

// File: rtl/preamble_lock_detector.sv
module preamble_lock_detector
  import lock_pkg::*;
#(
  parameter int ACQ_FRAMES = 3,
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic framePre,
  input  logic blockPre,
  input  logic slotTick,
  input  logic carrierOk,
  input  logic rateOk,
  output logic locked,
  output logic outOfLock,
  output logic lossStrobe
);
  lockCtl_t ctl;
  logic     acqFull;
  logic     missLast;
  logic     gateOk;

  assign gateOk = carrierOk & rateOk;

  lock_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .framePre  (framePre),
    .blockPre  (blockPre),
    .slotTick  (slotTick),
    .gateOk    (gateOk),
    .acqFull   (acqFull),
    .missLast  (missLast),
    .ctl       (ctl),
    .locked    (locked),
    .lossStrobe(lossStrobe)
  );

  lock_datapath #(
    .ACQ_FRAMES(ACQ_FRAMES),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .acqFull (acqFull),
    .missLast(missLast)
  );

  assign outOfLock = ~locked | ~gateOk;

endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic clk,
  input logic rstN,
  input logic framePre,
  input logic blockPre,
  input logic carrierOk,
  input logic rateOk,
  input logic locked,
  input logic outOfLock,
  input logic lossStrobe
);
  // R2: lock can only rise on an edge that sampled a block preamble
  a_r2_rise_on_block: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(blockPre));

  // R5: a preamble with the gate open keeps lock
  a_r5_preamble_holds: assert property (@(posedge clk) disable iff (!rstN)
    (locked && (framePre || blockPre) && carrierOk && rateOk) |=> locked);

  a_r8_no_carrier: assert property (@(posedge clk) disable iff (!rstN)
    !carrierOk |=> !locked);

  a_r9_bad_rate: assert property (@(posedge clk) disable iff (!rstN)
    !rateOk |=> !locked);

  // R10
  always_comb begin
    if (rstN) begin
      a_r10_status_level: assert (locked || outOfLock);
    end
  end

  a_r11_strobe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> lossStrobe);

  a_r11_strobe_only_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    lossStrobe |-> $fell(locked));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lossStrobe |=> !lossStrobe);

endmodule

bind preamble_lock_detector lock_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .framePre  (framePre),
  .blockPre  (blockPre),
  .carrierOk (carrierOk),
  .rateOk    (rateOk),
  .locked    (locked),
  .outOfLock (outOfLock),
  .lossStrobe(lossStrobe)
);

// File: tb/tb_preamble_lock_detector.sv
module tb_preamble_lock_detector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePre = 1'b0, blockPre = 1'b0, slotTick = 1'b0;
  logic carrierOk = 1'b1, rateOk = 1'b1;
  logic locked, outOfLock, lossStrobe;
  int   total = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  preamble_lock_detector dut (
    .clk(clk), .rstN(rstN), .framePre(framePre), .blockPre(blockPre),
    .slotTick(slotTick), .carrierOk(carrierOk), .rateOk(rateOk),
    .locked(locked), .outOfLock(outOfLock), .lossStrobe(lossStrobe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic fp, input logic bp, input logic st);
    framePre = fp; blockPre = bp; slotTick = st;
    @(posedge clk); #1;
    framePre = 1'b0; blockPre = 1'b0; slotTick = 1'b0;
  endtask

  task automatic clearGate();
    carrierOk = 1'b0;
    step(0, 0, 0);
    carrierOk = 1'b1;
  endtask

  task automatic acquire();
    clearGate();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 locked", locked, 1'b0);
    chk("R1 lossStrobe", lossStrobe, 1'b0);
    chk("R1 outOfLock", outOfLock, 1'b1);
    rstN = 1'b1;
    step(0, 0, 0);
    chk("R1 locked after release", locked, 1'b0);

    // R2/R3 sweep over the number of frames before a block preamble
    for (int k = 0; k <= 5; k++) begin
      clearGate();
      for (int i = 0; i < k; i++) step(1, 0, 0);
      chk("R2 locked before block", locked, 1'b0);
      step(0, 1, 0);
      chk((k >= 3) ? "R2 locks" : "R3 no lock", locked, (k >= 3));
      chk("R10 status", outOfLock, !(k >= 3));
    end

    // R3 restart of the count
    clearGate();
    step(1, 0, 0); step(1, 0, 0); step(0, 1, 0); step(1, 0, 0); step(0, 1, 0);
    chk("R3 count restarted", locked, 1'b0);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 0);
    chk("R3 relock after restart", locked, 1'b1);

    // R4 simultaneous frame and block while hunting
    clearGate();
    step(1, 0, 0); step(1, 0, 0); step(1, 1, 0);
    chk("R4 combined acts as block", locked, 1'b0);
    step(1, 0, 0); step(0, 1, 0);
    chk("R4 frame not counted", locked, 1'b0);
    clearGate();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(1, 1, 0);
    chk("R4 combined locks when full", locked, 1'b1);

    // R6/R11 sweep over consecutive misses
    for (int m = 1; m <= 6; m++) begin
      acquire();
      for (int i = 1; i <= m; i++) begin
        step(0, 0, 1);
        chk("R6 miss run", locked, (i < 4));
        chk("R11 strobe", lossStrobe, (i == 4));
      end
      step(0, 0, 0);
      chk("R11 strobe one cycle", lossStrobe, 1'b0);
    end

    // R5 frame and block preambles clear the miss run
    acquire();
    ticks(3); step(1, 0, 0); ticks(3);
    chk("R5 frame clears misses", locked, 1'b1);
    step(0, 1, 0); ticks(3);
    chk("R5 block clears misses", locked, 1'b1);
    ticks(1);
    chk("R5 fourth miss drops", locked, 1'b0);

    // R7 tick colliding with a preamble
    acquire();
    ticks(3); step(1, 0, 1); ticks(3);
    chk("R7 collided tick not a miss", locked, 1'b1);
    ticks(1);
    chk("R7 then fourth miss drops", locked, 1'b0);

    // R8 carrier loss
    acquire();
    carrierOk = 1'b0; #1;
    chk("R10 immediate on carrier", outOfLock, 1'b1);
    chk("R8 still locked before edge", locked, 1'b1);
    step(0, 0, 0);
    chk("R8 unlocked", locked, 1'b0);
    chk("R11 strobe on carrier loss", lossStrobe, 1'b1);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 0);
    chk("R8 no lock without carrier", locked, 1'b0);
    carrierOk = 1'b1;
    step(0, 1, 0);
    chk("R8 hunt count was cleared", locked, 1'b0);

    // R9 rate out of range
    acquire();
    rateOk = 1'b0; #1;
    chk("R10 immediate on rate", outOfLock, 1'b1);
    step(0, 0, 0);
    chk("R9 unlocked", locked, 1'b0);
    chk("R11 strobe on rate loss", lossStrobe, 1'b1);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 0);
    chk("R9 no lock at bad rate", locked, 1'b0);
    rateOk = 1'b1;
    step(0, 1, 0);
    chk("R9 hunt count was cleared", locked, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule